// File: doc/BRIEF.md
# Low-Power Clock Gating Controller

This block decides which bus clocks of a small microcontroller run. It supports two sleep depths. In the shallow one (doze) only the CPU clock is gated and the peripherals keep running. In the deep one (halt) every bus clock is gated and the oscillator enable is dropped. The CPU requests either depth with a one-cycle strobe. On entry to either depth the block emits a one-cycle pulse that tells the CPU to clear its interrupt mask.

Leaving halt is slower than leaving doze. After a qualifying wake event the block turns the oscillator back on. It then holds every clock gated for a stabilization delay counted in reference-clock cycles. The delay is long or short, and a configuration bit sampled at the moment halt is entered picks which one.

A sticky flag records that a sleep state was ended by a break interrupt. Software clears it by writing zero. While the system is in the break state, that clear only works when a clear-enable bit is set.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: While `rst_n` is sampled low, the block returns to the running state on that edge. After that edge `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `imask_clr` and `brk_exit_sts` are 0.
- R2: In the running state, a `wait_req` strobe (without `stop_req`) enters doze on the next edge. In doze `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1, and `imask_clr` is 1 for exactly the first cycle.
- R3: In the running state, a `stop_req` strobe enters halt on the next edge, and it wins when `wait_req` is high in the same cycle. In halt all three enables are 0, and `imask_clr` is 1 for exactly the first cycle.
- R4: Doze returns to the running state on the edge where any one of `ext_irq`, `int_irq`, `ext_rst`, `int_rst` or `brk_irq` is sampled high.
- R5: Halt ignores `int_irq`, `int_rst`, `wait_req` and `stop_req`. All enables stay 0 and no `imask_clr` pulse appears.
- R6: In halt, `ext_irq`, `ext_rst` or `brk_irq` moves the block on the next edge to recovery, where `osc_en`=1 and both clock enables are 0. Recovery lasts LONG_DLY (default 4096) cycles when the option bit was 0 at halt entry. The clock enables return on the edge after the last of those cycles.
- R7: `short_rec_cfg` is sampled only on the halt-entry edge. A 1 there gives a recovery of SHORT_DLY (default 32) cycles, and changing the bit afterwards has no effect.
- R8: `wait_req` and `stop_req` are ignored during recovery. After release the block is running, with no `imask_clr` pulse.
- R9: `brk_exit_sts` becomes 1 on the edge where `brk_irq` ends doze or halt.
- R10: A cycle with `sts_wr`=1 and `sts_wdata`=0 clears `brk_exit_sts` when `in_break`=0. A write with `sts_wdata`=1 leaves it unchanged.
- R11: With `in_break`=1, a zero write clears `brk_exit_sts` only when `brk_clr_en`=1.
- R12: When a break-caused exit and a clearing write fall in the same cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wait_req | input | 1 | CPU strobe requesting doze |
| stop_req | input | 1 | CPU strobe requesting halt |
| short_rec_cfg | input | 1 | Recovery length option, 1 = short |
| ext_irq | input | 1 | Unmasked external interrupt |
| int_irq | input | 1 | Unmasked internal interrupt |
| ext_rst | input | 1 | External reset request |
| int_rst | input | 1 | Internal reset request |
| brk_irq | input | 1 | Break interrupt |
| in_break | input | 1 | System is in the break state |
| brk_clr_en | input | 1 | Allows status clearing during break |
| sts_wr | input | 1 | Write strobe for the break-exit flag |
| sts_wdata | input | 1 | Data written to the break-exit flag |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| imask_clr | output | 1 | One-cycle pulse: clear the CPU interrupt mask |
| brk_exit_sts | output | 1 | Sleep was ended by a break interrupt |

## Verification
The hardest case to reach is a sleep request that arrives in the middle of a recovery count. It can only be set up by entering halt and waking it. The bench then drives a combined doze-and-halt strobe deep inside the 4096-cycle window, and counts edges from the wake to check that the release happens on exactly the computed cycle with no mask-clear pulse. The option bit is also toggled after halt entry, which shows the recovery length comes from the latched value and not the live one.

// File: rtl/lpm_clkgate_pkg.sv
// Shared types for the low-power clock gating controller.
package lpm_clkgate_pkg;
    // Power state of the controller: running, doze (CPU gated),
    // halt (all gated, oscillator off), resume (stabilization count).
    typedef enum logic [1:0] {
        LPM_RUN    = 2'd0,
        LPM_DOZE   = 2'd1,
        LPM_HALT   = 2'd2,
        LPM_RESUME = 2'd3
    } lpm_state_e;
endpackage

// File: rtl/lpm_mode_fsm.sv
// Power-state sequencer.
// Moves between run, doze, halt and resume. Produces the registered
// interrupt-mask-clear pulse on entry to a sleep depth and flags a
// break-caused exit. Assumes the wake inputs are already qualified
// (unmasked) and synchronous to clk.
module lpm_mode_fsm
    import lpm_clkgate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wait_req,
    input  logic       stop_req,
    input  logic       wake_doze,
    input  logic       wake_halt,
    input  logic       brk_irq,
    input  logic       resume_done,
    output lpm_state_e state,
    output logic       enter_halt,
    output logic       imask_clr,
    output logic       brk_wake
);
    lpm_state_e state_d;
    logic       enter_any;

    // Next-state selection; halt has priority over doze on entry.
    always_comb begin
        state_d = state;
        unique case (state)
            LPM_RUN: begin
                if (stop_req)      state_d = LPM_HALT;
                else if (wait_req) state_d = LPM_DOZE;
            end
            LPM_DOZE:   if (wake_doze)   state_d = LPM_RUN;
            LPM_HALT:   if (wake_halt)   state_d = LPM_RESUME;
            LPM_RESUME: if (resume_done) state_d = LPM_RUN;
            default:                     state_d = LPM_RUN;
        endcase
    end

    // Entry and break-exit decodes used by neighbours.
    always_comb begin
        enter_any  = (state == LPM_RUN) && (stop_req || wait_req);
        enter_halt = (state == LPM_RUN) && stop_req;
        brk_wake   = brk_irq && ((state == LPM_DOZE) || (state == LPM_HALT));
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= LPM_RUN;
        else        state <= state_d;
    end

    // One-cycle mask-clear pulse in the first cycle of a sleep depth.
    always_ff @(posedge clk) begin
        if (!rst_n) imask_clr <= 1'b0;
        else        imask_clr <= enter_any;
    end
endmodule

// File: rtl/lpm_stab_timer.sv
// Oscillator stabilization timer.
// Latches the short/long option on halt entry (the latch is not reset,
// matching an option bit that survives reset) and counts while in
// resume. The count is held at zero in every other state.
module lpm_stab_timer #(
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic latch_sel,
    input  logic short_sel,
    input  logic counting,
    output logic done
);
    localparam int CW = $clog2(LONG_DLY);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_DLY - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_DLY - 1);

    logic          short_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // Capture the recovery option at the halt-entry edge only.
    always_ff @(posedge clk) begin
        if (latch_sel) short_q <= short_sel;
    end

    // Cycle counter, cleared outside resume and on reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !counting) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // Terminal count for the latched option.
    always_comb begin
        last = short_q ? SHORT_LAST : LONG_LAST;
        done = counting && (cnt == last);
    end
endmodule

// File: rtl/lpm_brk_flag.sv
// Break-exit status flag.
// Set by a break-caused sleep exit; cleared by a zero write, which in
// the break state needs the clear-enable bit. Set beats clear.
module lpm_brk_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic wr,
    input  logic wdata,
    input  logic in_break,
    input  logic clr_en,
    output logic flag
);
    logic clr_ok;

    // Decide whether this cycle's write is allowed to clear.
    always_comb clr_ok = wr && !wdata && (!in_break || clr_en);

    // Flag register: reset, set priority, then permitted clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_ok)  flag <= 1'b0;
    end
endmodule

// File: rtl/lpm_clkgate_ctrl.sv
// Low-power clock gating controller (top).
// Gates CPU and peripheral clocks for doze and halt, drives the
// oscillator enable, times halt recovery and keeps the break-exit flag.
// Assumes all inputs are synchronous to clk; enables are to be used by
// glitch-free clock gates outside this block.
module lpm_clkgate_ctrl
    import lpm_clkgate_pkg::*;
#(
    parameter int LONG_DLY  = 4096,
    parameter int SHORT_DLY = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_req,
    input  logic stop_req,
    input  logic short_rec_cfg,
    input  logic ext_irq,
    input  logic int_irq,
    input  logic ext_rst,
    input  logic int_rst,
    input  logic brk_irq,
    input  logic in_break,
    input  logic brk_clr_en,
    input  logic sts_wr,
    input  logic sts_wdata,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic imask_clr,
    output logic brk_exit_sts
);
    lpm_state_e state;
    logic       wake_doze;
    logic       wake_halt;
    logic       enter_halt;
    logic       brk_wake;
    logic       resume_done;

    // Wake qualification: doze takes any source, halt only external ones.
    always_comb begin
        wake_doze = ext_irq || int_irq || ext_rst || int_rst || brk_irq;
        wake_halt = ext_irq || ext_rst || brk_irq;
    end

    lpm_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_req    (wait_req),
        .stop_req    (stop_req),
        .wake_doze   (wake_doze),
        .wake_halt   (wake_halt),
        .brk_irq     (brk_irq),
        .resume_done (resume_done),
        .state       (state),
        .enter_halt  (enter_halt),
        .imask_clr   (imask_clr),
        .brk_wake    (brk_wake)
    );

    lpm_stab_timer #(
        .LONG_DLY  (LONG_DLY),
        .SHORT_DLY (SHORT_DLY)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_sel (enter_halt),
        .short_sel (short_rec_cfg),
        .counting  (state == LPM_RESUME),
        .done      (resume_done)
    );

    lpm_brk_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (brk_wake),
        .wr       (sts_wr),
        .wdata    (sts_wdata),
        .in_break (in_break),
        .clr_en   (brk_clr_en),
        .flag     (brk_exit_sts)
    );

    // Clock and oscillator enables decoded from the state register.
    always_comb begin
        cpu_clk_en = (state == LPM_RUN);
        per_clk_en = (state == LPM_RUN) || (state == LPM_DOZE);
        osc_en     = (state != LPM_HALT);
    end
endmodule

// File: rtl/lpm_clkgate_ctrl_chk.sv
// Port-level property checker for the clock gating controller.
// Observes only top-level ports; the recovery window is bounded with a
// local counter instead of a long temporal delay.
module lpm_clkgate_ctrl_chk #(
    parameter int LONG_DLY = 4096
) (
    input logic clk,
    input logic rst_n,
    input logic wait_req,
    input logic stop_req,
    input logic ext_irq,
    input logic int_irq,
    input logic ext_rst,
    input logic int_rst,
    input logic brk_irq,
    input logic cpu_clk_en,
    input logic per_clk_en,
    input logic osc_en,
    input logic imask_clr,
    input logic brk_exit_sts
);
    localparam int RW = $clog2(LONG_DLY + 1);
    localparam logic [RW-1:0] REC_LIM = RW'(LONG_DLY);

    logic          rec;
    logic [RW-1:0] rec_len;

    // Recovery is visible as oscillator on with both clocks gated.
    always_comb rec = osc_en && !per_clk_en;

    // Length of the current recovery window so far.
    always_ff @(posedge clk) begin
        if (!rst_n)   rec_len <= '0;
        else if (rec) rec_len <= rec_len + 1'b1;
        else          rec_len <= '0;
    end

    assert_enable_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en |-> per_clk_en) and (per_clk_en |-> osc_en));

    assert_imask_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |=> !imask_clr);

    assert_imask_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        imask_clr |-> !cpu_clk_en);

    assert_doze_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_clk_en && per_clk_en && (ext_irq || int_irq || ext_rst || int_rst || brk_irq))
        |=> cpu_clk_en);

    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !ext_irq && !ext_rst && !brk_irq) |=> (!osc_en && !imask_clr));

    assert_halt_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && (ext_irq || ext_rst || brk_irq)) |=> (osc_en && !per_clk_en));

    assert_rec_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rec |-> (rec_len < REC_LIM));

    assert_no_entry_in_rec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec && (wait_req || stop_req)) |=> !imask_clr);

    assert_brk_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_irq && ((!cpu_clk_en && per_clk_en) || !osc_en)) |=> brk_exit_sts);
endmodule

bind lpm_clkgate_ctrl lpm_clkgate_ctrl_chk #(.LONG_DLY(LONG_DLY)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_req     (wait_req),
    .stop_req     (stop_req),
    .ext_irq      (ext_irq),
    .int_irq      (int_irq),
    .ext_rst      (ext_rst),
    .int_rst      (int_rst),
    .brk_irq      (brk_irq),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .osc_en       (osc_en),
    .imask_clr    (imask_clr),
    .brk_exit_sts (brk_exit_sts)
);

// File: tb/tb_lpm_clkgate_ctrl.sv
// Self-checking bench: a vector table walked by one loop, then directed
// tests for recovery timing, option latching and flag corner cases.
module tb_lpm_clkgate_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req, stop_req, short_rec_cfg, ext_irq, int_irq;
    logic ext_rst, int_rst, brk_irq, in_break, brk_clr_en, sts_wr, sts_wdata;
    logic cpu_clk_en, per_clk_en, osc_en, imask_clr, brk_exit_sts;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lpm_clkgate_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
        .short_rec_cfg(short_rec_cfg), .ext_irq(ext_irq), .int_irq(int_irq),
        .ext_rst(ext_rst), .int_rst(int_rst), .brk_irq(brk_irq),
        .in_break(in_break), .brk_clr_en(brk_clr_en), .sts_wr(sts_wr),
        .sts_wdata(sts_wdata), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .imask_clr(imask_clr), .brk_exit_sts(brk_exit_sts)
    );

    // Input word: [11]short [10]wait [9]stop [8]ext_irq [7]int_irq
    // [6]ext_rst [5]int_rst [4]brk_irq [3]sts_wr [2]wdata [1]in_break [0]clr_en
    // Expected word: {cpu_clk_en, per_clk_en, osc_en, imask_clr, brk_exit_sts}
    localparam int NV = 17;
    localparam logic [11:0] VIN [NV] = '{
        12'h000, 12'h400, 12'h000, 12'h080, 12'h400, 12'h040, 12'h400,
        12'h020, 12'h400, 12'h010, 12'h00C, 12'h00A, 12'h00B, 12'h600,
        12'h080, 12'h020, 12'h400};
    localparam logic [4:0] VEXP [NV] = '{
        5'b11100, 5'b01110, 5'b01100, 5'b11100, 5'b01110, 5'b11100, 5'b01110,
        5'b11100, 5'b01110, 5'b11101, 5'b11101, 5'b11101, 5'b11100, 5'b00010,
        5'b00000, 5'b00000, 5'b00000};
    localparam string VREQ [NV] = '{
        "R1", "R2", "R2", "R4", "R2", "R4", "R2", "R4", "R2", "R9",
        "R10", "R11", "R11", "R3", "R5", "R5", "R5"};

    task automatic drive(input logic [11:0] v);
        {short_rec_cfg, wait_req, stop_req, ext_irq, int_irq, ext_rst,
         int_rst, brk_irq, sts_wr, sts_wdata, in_break, brk_clr_en} = v;
    endtask

    // Apply one input word away from the edge, then sample after the edge.
    task automatic tick(input logic [11:0] v);
        @(negedge clk);
        drive(v);
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {cpu_clk_en, per_clk_en, osc_en, imask_clr, brk_exit_sts};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs %b, expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        drive(12'h000);
        repeat (3) @(posedge clk);
        #1;
        chk("R1", 5'b11100);            // R1: reset state
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: doze entries and exits, flag writes, halt entry.
        for (int i = 0; i < NV; i++) begin
            tick(VIN[i]);
            chk(VREQ[i], VEXP[i]);
        end

        // R6: long recovery (option was 0 at halt entry); the option is
        // raised now and must not matter. R8: requests mid-count ignored.
        tick(12'h900);
        chk("R6", 5'b00100);
        for (int k = 1; k < 4096; k++) begin
            if (k == 10) begin
                tick(12'h600);
                chk("R8", 5'b00100);
            end else begin
                tick(12'h000);
            end
        end
        chk("R6", 5'b00100);            // 4096 edges after wake: still held
        tick(12'h000);
        chk("R6", 5'b11100);            // released on edge 4097
        tick(12'h000);
        chk("R8", 5'b11100);            // no late entry from the ignored request

        // R7: short option latched at entry, cleared afterwards.
        tick(12'hA00);
        chk("R7", 5'b00010);
        tick(12'h040);
        chk("R7", 5'b00100);
        for (int k = 1; k < 32; k++) tick(12'h000);
        chk("R7", 5'b00100);
        tick(12'h000);
        chk("R7", 5'b11100);

        // R9: break ends halt and sets the flag; R10: plain clear.
        tick(12'hA00);
        chk("R3", 5'b00010);
        tick(12'h010);
        chk("R9", 5'b00101);
        for (int k = 0; k < 32; k++) tick(12'h000);
        chk("R9", 5'b11101);
        tick(12'h008);
        chk("R10", 5'b11100);

        // R12: break exit and clearing write in the same cycle.
        tick(12'h400);
        chk("R2", 5'b01110);
        tick(12'h018);
        chk("R12", 5'b11101);

        // R1: reset from doze with the flag set.
        tick(12'h400);
        chk("R2", 5'b01111);
        @(negedge clk);
        rst_n = 1'b0;
        drive(12'h000);
        @(posedge clk);
        #1;
        chk("R1", 5'b11100);
        @(negedge clk);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule